// File: doc/BRIEF.md
# Sleep Mode Controller for a Small Microcontroller

This block decides when a small processor core may stop and which clock domains stop with it. Software writes an 8-bit control register that holds a sleep-enable flag and a two-bit mode code. When the core reports that it has executed a sleep instruction and the flag is set, the block enters the selected low-power mode. It drives one clock-enable output for each of these domains: CPU, program flash, general I/O, asynchronous wake logic. It also drives an oscillator-run output.

While asleep, the block watches the interrupt requests and their enable bits, along with a chip reset request. A qualifying event wakes it. It then counts a start-up delay that depends on the mode, followed by a fixed four-cycle halt. After that it releases the CPU with a one-cycle pulse. In the same cycle it states whether the core must resume after the sleep instruction or restart at the reset vector. An interrupt wake also forwards the interrupt-service request in that cycle.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `status_o` is 0 (Active), every clock enable and `osc_run_o` are 1, and `release_o`, `restart_vec_o` and `irq_fwd_o` are 0.
- R2: A write stores all 8 bits, which read back on `ctl_rdata_o` from the next cycle. Bit 6 is mode bit 1, bit 5 is sleep-enable and bit 4 is mode bit 0. The other bits have no effect on the block.
- R3: A sleep instruction with sleep-enable at 0 changes nothing: status stays 0 and all enables stay 1.
- R4: A sleep instruction with sleep-enable at 1 sets status to 1 (Sleeping) in the next cycle.
- R5: Mode code {bit6,bit4} selects the mode: 00 = Idle, 01 = Power-down, 10 = Standby, 11 = Power-down. While sleeping, each mode drives the enables {cpu,flash,io,async,osc} as follows: Idle drives 0,0,1,1,1. Power-down drives 0,0,0,1,0. Standby drives 0,0,0,1,1.
- R6: In Idle or Standby, any request whose enable bit is 1 wakes the block. A request whose enable bit is 0 does not.
- R7: In Power-down, only an enabled request whose asynchronous flag is 1 wakes the block.
- R8: After a wake edge, status is 2 (Starting-up) for STARTUP_LONG cycles after Power-down, or STARTUP_SHORT cycles otherwise. It is then 3 (Halt) for 4 cycles. `release_o` pulses in the first cycle that status is back to 0, which is delay+4 cycles after the wake edge. During Starting-up and Halt the enables are 0,0,1,1,1.
- R9: At the release after an interrupt wake, `irq_fwd_o` is 1 and `restart_vec_o` is 0.
- R10: A reset request during Sleeping wakes the block in any mode. A reset request during Starting-up or Halt also turns the wake into a restart. In both cases the release shows `restart_vec_o` 1 and `irq_fwd_o` 0.
- R11: The mode is captured at sleep entry. Register writes made while sleeping do not change the gating of the current sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register contents |
| sleep_exec_i | input | 1 | Core executed a sleep instruction this cycle |
| irq_req_i | input | N_IRQ | Pending interrupt requests |
| irq_en_i | input | N_IRQ | Interrupt enable bits |
| irq_async_i | input | N_IRQ | Request is detectable without clocks |
| rst_req_i | input | 1 | Chip reset request observed during sleep |
| clken_cpu_o | output | 1 | CPU clock enable |
| clken_flash_o | output | 1 | Flash clock enable |
| clken_io_o | output | 1 | I/O clock enable |
| clken_async_o | output | 1 | Asynchronous wake logic clock enable |
| osc_run_o | output | 1 | Main oscillator keeps running |
| status_o | output | 2 | 0 Active, 1 Sleeping, 2 Starting-up, 3 Halt |
| release_o | output | 1 | One-cycle pulse when the CPU is released |
| restart_vec_o | output | 1 | With release: restart at the reset vector |
| irq_fwd_o | output | 1 | With release: forward the interrupt request |

## Verification
The hardest case to reach is a reset request that arrives after an interrupt has already started the wake sequence. The request must still turn the release into a restart, even though the block is no longer Sleeping. The stimulus wakes from Idle with an enabled request. One cycle into Starting-up, it drives the reset request. It then expects the release at the same cycle as for a plain interrupt wake, but with the restart flag set. A second hard case is a Power-down sleep that must ignore enabled but synchronous requests. The bench drives such a request, confirms that the block stays Sleeping, and only then wakes it with an asynchronous one.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

    localparam int CTL_W       = 8;
    localparam int MSEL1_BIT   = 6;
    localparam int SEN_BIT     = 5;
    localparam int MSEL0_BIT   = 4;
    localparam int HALT_CYCLES = 4;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_STARTUP = 2'd2,
        ST_HALT    = 2'd3
    } pwr_state_e;

    typedef enum logic [1:0] {
        MD_IDLE    = 2'd0,
        MD_PWRDN   = 2'd1,
        MD_STANDBY = 2'd2
    } pwr_mode_e;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic asyn;
        logic osc;
    } clk_en_t;

    typedef struct packed {
        logic       sen;
        logic [1:0] msel;
    } ctl_fields_t;

    // Two codes map onto power-down.
    function automatic pwr_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'b00:   return MD_IDLE;
            2'b10:   return MD_STANDBY;
            default: return MD_PWRDN;
        endcase
    endfunction

    function automatic clk_en_t gate_for(input pwr_state_e st, input pwr_mode_e md);
        clk_en_t e;
        e = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, asyn: 1'b1, osc: 1'b1};
        case (st)
            ST_ACTIVE: ;
            ST_SLEEP: begin
                e.cpu   = 1'b0;
                e.flash = 1'b0;
                if (md != MD_IDLE) e.io  = 1'b0;
                if (md == MD_PWRDN) e.osc = 1'b0;
            end
            default: begin
                e.cpu   = 1'b0;
                e.flash = 1'b0;
            end
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pwr_sleep_ctlreg.sv
module pwr_sleep_ctlreg
    import pwr_sleep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] wdata_i,
    output logic [CTL_W-1:0] rdata_o,
    output ctl_fields_t      fields_o
);
    logic [CTL_W-1:0] ctl_q;

    always_ff @(posedge clk) begin
        if (rst)       ctl_q <= '0;
        else if (wr_i) ctl_q <= wdata_i;
    end

    assign rdata_o       = ctl_q;
    assign fields_o.sen  = ctl_q[SEN_BIT];
    assign fields_o.msel = {ctl_q[MSEL1_BIT], ctl_q[MSEL0_BIT]};

    // R2: written value is visible the cycle after the write
    p_readback_r2: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> rdata_o == $past(wdata_i));

endmodule

// File: rtl/pwr_sleep_wake.sv
module pwr_sleep_wake
    import pwr_sleep_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  pwr_mode_e        mode_i,
    input  logic [N_IRQ-1:0] req_i,
    input  logic [N_IRQ-1:0] en_i,
    input  logic [N_IRQ-1:0] async_i,
    input  logic             rst_req_i,
    output logic             wake_o,
    output logic             wake_rst_o
);
    logic [N_IRQ-1:0] qual;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_qual
        always_comb begin
            if (mode_i == MD_PWRDN) qual[i] = req_i[i] & en_i[i] & async_i[i];
            else                    qual[i] = req_i[i] & en_i[i];
        end
    end

    assign wake_rst_o = rst_req_i;
    assign wake_o     = rst_req_i | (|qual);

    // R7: without a reset request, power-down wake needs an enabled async request
    p_pd_async_only_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MD_PWRDN && wake_o && !rst_req_i) |-> |(req_i & en_i & async_i));

    // R6: a wake without reset request always has some enabled request behind it
    p_wake_has_source_r6: assert property (@(posedge clk) disable iff (rst)
        (wake_o && !rst_req_i) |-> |(req_i & en_i));

endmodule

// File: rtl/pwr_sleep_seq.sv
module pwr_sleep_seq
    import pwr_sleep_pkg::*;
#(
    parameter int STARTUP_SHORT = 6,
    parameter int STARTUP_LONG  = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_exec_i,
    input  logic       sen_i,
    input  pwr_mode_e  mode_sel_i,
    input  logic       wake_i,
    input  logic       rst_req_i,
    output pwr_state_e state_o,
    output pwr_mode_e  mode_o,
    output logic       release_o,
    output logic       cause_rst_o
);
    localparam int MAX_CNT = (STARTUP_LONG > STARTUP_SHORT) ?
                             ((STARTUP_LONG > HALT_CYCLES) ? STARTUP_LONG : HALT_CYCLES) :
                             ((STARTUP_SHORT > HALT_CYCLES) ? STARTUP_SHORT : HALT_CYCLES);
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'(STARTUP_LONG - 1);
    localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(STARTUP_SHORT - 1);
    localparam logic [CNT_W-1:0] LOAD_HALT  = CNT_W'(HALT_CYCLES - 1);

    pwr_state_e       state_q;
    pwr_mode_e        mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             release_q;
    logic             cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_ACTIVE;
            mode_q    <= MD_IDLE;
            cnt_q     <= '0;
            release_q <= 1'b0;
            cause_q   <= 1'b0;
        end else begin
            release_q <= 1'b0;
            case (state_q)
                ST_ACTIVE: begin
                    if (sleep_exec_i && sen_i) begin
                        state_q <= ST_SLEEP;
                        mode_q  <= mode_sel_i;
                        cause_q <= 1'b0;
                    end
                end
                ST_SLEEP: begin
                    if (wake_i) begin
                        state_q <= ST_STARTUP;
                        cnt_q   <= (mode_q == MD_PWRDN) ? LOAD_LONG : LOAD_SHORT;
                        cause_q <= rst_req_i;
                    end
                end
                ST_STARTUP: begin
                    if (rst_req_i) cause_q <= 1'b1;
                    if (cnt_q == '0) begin
                        state_q <= ST_HALT;
                        cnt_q   <= LOAD_HALT;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_HALT: begin
                    if (rst_req_i) cause_q <= 1'b1;
                    if (cnt_q == '0) begin
                        state_q   <= ST_ACTIVE;
                        release_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= ST_ACTIVE;
            endcase
        end
    end

    assign state_o     = state_q;
    assign mode_o      = mode_q;
    assign release_o   = release_q;
    assign cause_rst_o = cause_q;

    // R3: sleep instruction without enable keeps the core active
    p_no_sleep_without_enable_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && sleep_exec_i && !sen_i) |=> state_q == ST_ACTIVE);

    // R4: enabled sleep instruction enters sleep
    p_sleep_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && sleep_exec_i && sen_i) |=> state_q == ST_SLEEP);

    // R6: wake moves to start-up; no wake keeps sleeping
    p_wake_to_startup_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && wake_i) |=> state_q == ST_STARTUP);
    p_stay_asleep_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && !wake_i) |=> state_q == ST_SLEEP);

    // R8: halt follows start-up, release only right after halt
    p_startup_to_halt_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STARTUP && cnt_q == '0) |=> state_q == ST_HALT);
    p_release_after_halt_r8: assert property (@(posedge clk) disable iff (rst)
        release_o |-> (state_q == ST_ACTIVE && $past(state_q) == ST_HALT));

    // R10: a reset request seen during wake-up always marks a restart
    p_rst_cause_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (rst_req_i && (state_q == ST_STARTUP || state_q == ST_HALT)) |=> cause_q);

endmodule

// File: rtl/pwr_sleep_clkgate.sv
module pwr_sleep_clkgate
    import pwr_sleep_pkg::*;
(
    input  pwr_state_e state_i,
    input  pwr_mode_e  mode_i,
    output clk_en_t    en_o
);
    always_comb en_o = gate_for(state_i, mode_i);
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int N_IRQ         = 8,
    parameter int STARTUP_SHORT = 6,
    parameter int STARTUP_LONG  = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr_i,
    input  logic [7:0]       ctl_wdata_i,
    output logic [7:0]       ctl_rdata_o,
    input  logic             sleep_exec_i,
    input  logic [N_IRQ-1:0] irq_req_i,
    input  logic [N_IRQ-1:0] irq_en_i,
    input  logic [N_IRQ-1:0] irq_async_i,
    input  logic             rst_req_i,
    output logic             clken_cpu_o,
    output logic             clken_flash_o,
    output logic             clken_io_o,
    output logic             clken_async_o,
    output logic             osc_run_o,
    output logic [1:0]       status_o,
    output logic             release_o,
    output logic             restart_vec_o,
    output logic             irq_fwd_o
);
    ctl_fields_t fields;
    pwr_mode_e   mode_sel;
    pwr_mode_e   mode_cur;
    pwr_state_e  state;
    logic        wake;
    logic        wake_rst;
    logic        rel;
    logic        cause_rst;
    clk_en_t     en;

    pwr_sleep_ctlreg u_ctl (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (ctl_wr_i),
        .wdata_i  (ctl_wdata_i),
        .rdata_o  (ctl_rdata_o),
        .fields_o (fields)
    );

    assign mode_sel = decode_mode(fields.msel);

    pwr_sleep_wake #(.N_IRQ(N_IRQ)) u_wake (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode_cur),
        .req_i      (irq_req_i),
        .en_i       (irq_en_i),
        .async_i    (irq_async_i),
        .rst_req_i  (rst_req_i),
        .wake_o     (wake),
        .wake_rst_o (wake_rst)
    );

    pwr_sleep_seq #(
        .STARTUP_SHORT (STARTUP_SHORT),
        .STARTUP_LONG  (STARTUP_LONG)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .sleep_exec_i (sleep_exec_i),
        .sen_i        (fields.sen),
        .mode_sel_i   (mode_sel),
        .wake_i       (wake),
        .rst_req_i    (wake_rst),
        .state_o      (state),
        .mode_o       (mode_cur),
        .release_o    (rel),
        .cause_rst_o  (cause_rst)
    );

    pwr_sleep_clkgate u_gate (
        .state_i (state),
        .mode_i  (mode_cur),
        .en_o    (en)
    );

    assign clken_cpu_o   = en.cpu;
    assign clken_flash_o = en.flash;
    assign clken_io_o    = en.io;
    assign clken_async_o = en.asyn;
    assign osc_run_o     = en.osc;
    assign status_o      = state;
    assign release_o     = rel;
    assign restart_vec_o = rel & cause_rst;
    assign irq_fwd_o     = rel & ~cause_rst;

    // R5: the oscillator stops only while sleeping in power-down
    p_osc_only_pd_r5: assert property (@(posedge clk) disable iff (rst)
        !osc_run_o |-> (status_o == 2'd1 && mode_cur == MD_PWRDN));

    // R5: the asynchronous wake logic never loses its clock
    p_async_always_on_r5: assert property (@(posedge clk) disable iff (rst)
        clken_async_o);

    // R8: CPU is clocked only when the sequencer reports Active
    p_cpu_gated_r8: assert property (@(posedge clk) disable iff (rst)
        clken_cpu_o |-> status_o == 2'd0);

    // R9: release carries exactly one of the two resume choices
    p_one_cause_r9: assert property (@(posedge clk) disable iff (rst)
        release_o |-> (restart_vec_o ^ irq_fwd_o));

endmodule

// File: tb/pwr_sleep_ctrl_test.sv
module pwr_sleep_ctrl_test;

    localparam int N     = 8;
    localparam int SHORT = 5;
    localparam int LONG  = 40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ctl_wr = 1'b0;
    logic [7:0]   ctl_wdata = '0;
    logic [7:0]   ctl_rdata;
    logic         sleep_exec = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic [N-1:0] irq_en = '0;
    logic [N-1:0] irq_async = '0;
    logic         rst_req = 1'b0;
    logic         en_cpu, en_flash, en_io, en_async, osc_run;
    logic [1:0]   status;
    logic         rel, rvec, ifwd;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        int    at;
        bit    vec;
        string req;
    } rel_item_t;

    rel_item_t exp_q[$];

    pwr_sleep_ctrl #(.N_IRQ(N), .STARTUP_SHORT(SHORT), .STARTUP_LONG(LONG)) uut (
        .clk(clk), .rst(rst), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
        .ctl_rdata_o(ctl_rdata), .sleep_exec_i(sleep_exec), .irq_req_i(irq_req),
        .irq_en_i(irq_en), .irq_async_i(irq_async), .rst_req_i(rst_req),
        .clken_cpu_o(en_cpu), .clken_flash_o(en_flash), .clken_io_o(en_io),
        .clken_async_o(en_async), .osc_run_o(osc_run), .status_o(status),
        .release_o(rel), .restart_vec_o(rvec), .irq_fwd_o(ifwd)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: pops the scoreboard whenever the CPU is released
    always @(negedge clk) begin
        if (!rst && rel) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected release", 32'd1, 32'd0);
            end else begin
                rel_item_t it;
                it = exp_q.pop_front();
                check({it.req, " release cycle"}, cyc, it.at);
                check({it.req, " restart flag"}, {31'd0, rvec}, {31'd0, it.vec});
                check({it.req, " irq forward"}, {31'd0, ifwd}, {31'd0, ~it.vec});
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic write_ctl(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        step();
        ctl_wr = 1'b0;
    endtask

    task automatic check_en(input string req, input logic [4:0] exp);
        check(req, {27'd0, en_cpu, en_flash, en_io, en_async, osc_run}, {27'd0, exp});
    endtask

    task automatic do_sleep();
        sleep_exec = 1'b1;
        step();
        sleep_exec = 1'b0;
    endtask

    // Driver: raises a wake source and pushes the expected release
    task automatic wake(input logic [N-1:0] req, input bit by_rst, input int dly, input string tag);
        int k;
        rel_item_t it;
        k = cyc;
        irq_req = req;
        rst_req = by_rst;
        it.at = k + 1 + dly + 4; it.vec = by_rst; it.req = tag;
        exp_q.push_back(it);
        step();
        irq_req = '0;
        rst_req = 1'b0;
        check({tag, " R8 starting-up"}, status, 2);
        check_en({tag, " R8 enables in start-up"}, 5'b00111);
        wait_until(k + 1 + dly);
        check({tag, " R8 halt after delay"}, status, 3);
        wait_until(k + 1 + dly + 4);
        check({tag, " R8 active at release"}, status, 0);
        step();
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        check("R1 status", status, 0);
        check("R1 register", ctl_rdata, 8'h00);
        check_en("R1 enables", 5'b11111);
        check("R1 release quiet", {rel, rvec, ifwd}, 0);

        // R2 register readback
        write_ctl(8'hA5);
        check("R2 readback", ctl_rdata, 8'hA5);
        write_ctl(8'h00);

        // R3 sleep ignored without enable (mode 10, other bits set)
        write_ctl(8'h4F);
        do_sleep();
        check("R3 status stays active", status, 0);
        check_en("R3 enables stay on", 5'b11111);

        // Idle: SE=1 code 00
        irq_en = 8'b0000_0010;
        write_ctl(8'h20);
        do_sleep();
        check("R4 sleeping", status, 1);
        check_en("R5 idle enables", 5'b00111);
        write_ctl(8'h30);
        check_en("R11 gating unchanged by write", 5'b00111);
        irq_req = 8'b0000_0001;
        step();
        irq_req = '0;
        step();
        check("R6 disabled request ignored", status, 1);
        wake(8'b0000_0010, 1'b0, SHORT, "R9 idle irq wake");

        // Power-down code 01
        irq_async = 8'b0000_0100;
        irq_en    = 8'b0000_0110;
        write_ctl(8'h30);
        do_sleep();
        check("R5 power-down code 01 enables", {27'd0, en_cpu, en_flash, en_io, en_async, osc_run}, {27'd0, 5'b00010});
        irq_req = 8'b0000_0010;
        step();
        irq_req = '0;
        step();
        check("R7 sync request ignored in power-down", status, 1);
        wake(8'b0000_0100, 1'b0, LONG, "R7 async wake");

        // Power-down code 11
        write_ctl(8'h70);
        do_sleep();
        check_en("R5 power-down code 11 enables", 5'b00010);
        wake(8'b0000_0100, 1'b0, LONG, "R5 code 11 wake");

        // Standby code 10, woken by a synchronous request
        write_ctl(8'h60);
        do_sleep();
        check_en("R5 standby enables", 5'b00011);
        wake(8'b0000_0010, 1'b0, SHORT, "R6 standby wake");

        // Reset request wakes Idle
        write_ctl(8'h20);
        do_sleep();
        wake('0, 1'b1, SHORT, "R10 reset wake idle");

        // Reset request wakes power-down
        write_ctl(8'h30);
        do_sleep();
        wake('0, 1'b1, LONG, "R10 reset wake power-down");

        // Reset request during start-up converts an interrupt wake
        write_ctl(8'h20);
        do_sleep();
        begin
            int k;
            rel_item_t it;
            k = cyc;
            irq_req = 8'b0000_0010;
            it.at = k + 1 + SHORT + 4; it.vec = 1'b1; it.req = "R10 reset during start-up";
            exp_q.push_back(it);
            step();
            irq_req = '0;
            rst_req = 1'b1;
            step();
            rst_req = 1'b0;
            wait_until(k + 1 + SHORT + 4);
            step();
        end

        repeat (3) step();
        check("R8 all releases seen", exp_q.size(), 0);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    tests++;
                    fails++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
            end
            wait (done);
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule